// File: doc/BRIEF.md
# Processor Debug Hex Display Selector

This block lets an engineer look inside a small single-cycle processor while stepping it by hand. Eight internal 32-bit values come in. Three active-low pushbuttons pick one of them, and a slide switch picks the low or high 16-bit half. The chosen half is shown on four active-low seven-segment digits as hexadecimal.

One source is a 10-bit word that packs the processor's control signals. When that source is picked, the half switch does nothing. The word is zero-extended and shown in the low 16 bits, so each control line that is set on its own shows up as a single power-of-two hex value. The path from the sources to the segments has no registers. The display therefore changes in the same cycle that processor state changes.

Top module: `dbg_hex_view`

## Requirements
- R1: The view code is {~btn_n_i[2], ~btn_n_i[1], ~btn_n_i[0]}. Buttons are active-low and btn_n_i[2] is the most significant bit.
- R2: View codes 0 to 3 select, in that order, pc_i, instr_i, rdata_a_i and rdata_b_i.
- R3: View codes 4 to 6 select, in that order, alu_res_i, br_tgt_i and mem_rdata_i.
- R4: View code 7 selects the control word zero-extended from 10 bits: {22'b0, ctrl_i}.
- R5: With view codes 0 to 6, half_sel_i = 0 shows bits 15:0 of the selected source and half_sel_i = 1 shows bits 31:16.
- R6: With view code 7, half_sel_i has no effect and bits 15:0 of the zero-extended control word are shown.
- R7: Control bits, from bit 9 down to bit 0, are: register-destination select, jump, branch, memory read, memory-to-register, ALU op bit 1, ALU op bit 0, memory write, ALU source select, register write. Bit k set alone shows as the hex value 2^k.
- R8: seg3_no shows nibble 15:12, seg2_no nibble 11:8, seg1_no nibble 7:4 and seg0_no nibble 3:0. Each output is {g,f,e,d,c,b,a}, and a 0 lights a segment. The glyphs are 0-9, A, lowercase b, C, lowercase d, E and F. For example, 0 is 7'h40, 8 is 7'h00 and F is 7'h0E.
- R9: The path is combinational. A change on any input shows on the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only by the assertions |
| rst_ni | input | 1 | Active-low asynchronous reset, used only by the assertions |
| pc_i | input | 32 | Program counter |
| instr_i | input | 32 | Current instruction |
| rdata_a_i | input | 32 | Register read data, port A |
| rdata_b_i | input | 32 | Register read data, port B |
| alu_res_i | input | 32 | ALU result |
| br_tgt_i | input | 32 | Branch target address |
| mem_rdata_i | input | 32 | Data memory read data |
| ctrl_i | input | 10 | Packed control signals |
| btn_n_i | input | 3 | Active-low view-select buttons |
| half_sel_i | input | 1 | 0 shows the low half, 1 shows the high half |
| seg3_no | output | 7 | Leftmost digit, active-low segments |
| seg2_no | output | 7 | Digit 2, active-low segments |
| seg1_no | output | 7 | Digit 1, active-low segments |
| seg0_no | output | 7 | Rightmost digit, active-low segments |

## Verification
The case that is hardest to reach is the half switch being ignored for the control word. It only shows when half_sel_i = 1 and every other source carries distinct, non-zero upper halves. Otherwise a design that leaks the high half, or a wrong source, would still show zeros. The stimulus fills every source with a unique pattern in both halves. It then applies view code 7 with the switch in both positions and sets each control bit alone in turn. The lowercase glyphs b and d are reached with a pattern that holds all sixteen nibble values.

// File: rtl/dbg_hex_pkg.sv
package dbg_hex_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 10;
  localparam int unsigned NSRC   = 8;
  localparam int unsigned SEL_W  = $clog2(NSRC);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NDIG   = HALF_W / 4;
  localparam int unsigned SEG_W  = 7;

  typedef enum logic [SEL_W-1:0] {
    VIEW_PC   = 3'd0,
    VIEW_INSN = 3'd1,
    VIEW_RDA  = 3'd2,
    VIEW_RDB  = 3'd3,
    VIEW_ALU  = 3'd4,
    VIEW_BRT  = 3'd5,
    VIEW_MEM  = 3'd6,
    VIEW_CTRL = 3'd7
  } view_e;

  // active-low {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] n);
    logic [SEG_W-1:0] on;
    case (n)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/dbg_src_mux.sv
module dbg_src_mux
  import dbg_hex_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned CW = CTRL_W
) (
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     instr_i,
  input  logic [W-1:0]     rdata_a_i,
  input  logic [W-1:0]     rdata_b_i,
  input  logic [W-1:0]     alu_res_i,
  input  logic [W-1:0]     br_tgt_i,
  input  logic [W-1:0]     mem_rdata_i,
  input  logic [CW-1:0]    ctrl_i,
  input  logic [SEL_W-1:0] view_i,
  output logic [W-1:0]     word_o,
  output logic             is_ctrl_o
);
  always_comb begin
    unique case (view_e'(view_i))
      VIEW_PC:   word_o = pc_i;
      VIEW_INSN: word_o = instr_i;
      VIEW_RDA:  word_o = rdata_a_i;
      VIEW_RDB:  word_o = rdata_b_i;
      VIEW_ALU:  word_o = alu_res_i;
      VIEW_BRT:  word_o = br_tgt_i;
      VIEW_MEM:  word_o = mem_rdata_i;
      default:   word_o = {{(W-CW){1'b0}}, ctrl_i};
    endcase
  end
  assign is_ctrl_o = (view_i == VIEW_CTRL);
endmodule

// File: rtl/dbg_half_pick.sv
module dbg_half_pick
  import dbg_hex_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned HW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  word_i,
  input  logic          half_sel_i,
  input  logic          is_ctrl_i,
  output logic [HW-1:0] half_o
);
  logic use_hi;
  assign use_hi = half_sel_i & ~is_ctrl_i;
  assign half_o = use_hi ? word_i[W-1:HW] : word_i[HW-1:0];

  // R6
  ctrl_low_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ctrl_i |-> half_o == word_i[HW-1:0]);
  // R5
  hi_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_sel_i && !is_ctrl_i) |-> half_o == word_i[W-1:HW]);
endmodule

// File: rtl/dbg_seg_bank.sv
module dbg_seg_bank
  import dbg_hex_pkg::*;
#(
  parameter int unsigned ND = NDIG
) (
  input  logic [4*ND-1:0]    val_i,
  output logic [SEG_W*ND-1:0] seg_no
);
  for (genvar d = 0; d < ND; d++) begin : g_dig
    assign seg_no[SEG_W*d +: SEG_W] = hex_glyph(val_i[4*d +: 4]);
  end
endmodule

// File: rtl/dbg_hex_view.sv
module dbg_hex_view
  import dbg_hex_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rdata_a_i,
  input  logic [DATA_W-1:0] rdata_b_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W-1:0] br_tgt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [SEL_W-1:0]  btn_n_i,
  input  logic              half_sel_i,
  output logic [SEG_W-1:0]  seg3_no,
  output logic [SEG_W-1:0]  seg2_no,
  output logic [SEG_W-1:0]  seg1_no,
  output logic [SEG_W-1:0]  seg0_no
);
  logic [SEL_W-1:0]      view;
  logic [DATA_W-1:0]     word;
  logic                  is_ctrl;
  logic [HALF_W-1:0]     half;
  logic [SEG_W*NDIG-1:0] segs;

  // R1: buttons pressed pull low
  assign view = ~btn_n_i;

  dbg_src_mux #(.W(DATA_W), .CW(CTRL_W)) u_mux (
    .pc_i, .instr_i, .rdata_a_i, .rdata_b_i, .alu_res_i, .br_tgt_i,
    .mem_rdata_i, .ctrl_i, .view_i(view), .word_o(word), .is_ctrl_o(is_ctrl)
  );

  dbg_half_pick #(.W(DATA_W)) u_half (
    .clk_i, .rst_ni, .word_i(word), .half_sel_i, .is_ctrl_i(is_ctrl), .half_o(half)
  );

  dbg_seg_bank #(.ND(NDIG)) u_seg (.val_i(half), .seg_no(segs));

  assign {seg3_no, seg2_no, seg1_no, seg0_no} = segs;

  // R4
  ctrl_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_n_i == 3'b000) |-> word == {{(DATA_W-CTRL_W){1'b0}}, ctrl_i});
  // R2
  pc_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_n_i == 3'b111) |-> word == pc_i);
  // R3
  mem_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_n_i == 3'b001) |-> word == mem_rdata_i);
  // R6
  ctrl_top_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btn_n_i == 3'b000) |-> seg3_no == 7'h40);
  // R9
  follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(half) |-> $stable(segs));
endmodule

// File: tb/sim_dbg_hex_view.sv
module sim_dbg_hex_view;
  logic clk = 0, rst_n = 0;
  always #4ns clk = ~clk;

  logic [31:0] src [7];
  logic [9:0]  ctrl;
  logic [2:0]  btn_n;
  logic        half;
  logic [6:0]  s3, s2, s1, s0;
  int checks = 0, fails = 0;
  bit done = 0;

  dbg_hex_view u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(src[0]), .instr_i(src[1]),
    .rdata_a_i(src[2]), .rdata_b_i(src[3]), .alu_res_i(src[4]),
    .br_tgt_i(src[5]), .mem_rdata_i(src[6]), .ctrl_i(ctrl),
    .btn_n_i(btn_n), .half_sel_i(half),
    .seg3_no(s3), .seg2_no(s2), .seg1_no(s1), .seg0_no(s0)
  );

  function automatic logic [6:0] ref_glyph(input logic [3:0] n);
    logic [6:0] g;
    case (n)
      0: g=7'h40; 1: g=7'h79; 2: g=7'h24; 3: g=7'h30; 4: g=7'h19; 5: g=7'h12;
      6: g=7'h02; 7: g=7'h78; 8: g=7'h00; 9: g=7'h10; 10: g=7'h08; 11: g=7'h03;
      12: g=7'h46; 13: g=7'h21; 14: g=7'h06; default: g=7'h0E;
    endcase
    return g;
  endfunction

  task automatic expect_hex(input logic [15:0] v, input string req);
    logic [27:0] got, exp;
    #1ns;
    got = {s3, s2, s1, s0};
    exp = {ref_glyph(v[15:12]), ref_glyph(v[11:8]), ref_glyph(v[7:4]), ref_glyph(v[3:0])};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: segs %h expected %h (value %h)", req, got, exp, v);
    end
  endtask

  // {view code, half, expected 16-bit value}
  typedef struct packed { logic [2:0] v; logic h; logic [15:0] e; } vec_t;
  localparam vec_t VECS [14] = '{
    '{3'd0,1'b0,16'h0000}, '{3'd0,1'b1,16'h1000}, '{3'd1,1'b0,16'h0111},
    '{3'd1,1'b1,16'h1101}, '{3'd2,1'b0,16'h0222}, '{3'd2,1'b1,16'h1202},
    '{3'd3,1'b0,16'h0333}, '{3'd3,1'b1,16'h1303}, '{3'd4,1'b0,16'h0444},
    '{3'd4,1'b1,16'h1404}, '{3'd5,1'b0,16'h0555}, '{3'd5,1'b1,16'h1505},
    '{3'd6,1'b0,16'h0666}, '{3'd6,1'b1,16'h1606}
  };

  initial begin
    for (int i = 0; i < 7; i++) src[i] = {4'h1, i[3:0], 4'h0, i[3:0], 4'h0, i[3:0], i[3:0], i[3:0]};
    ctrl = 10'h000; btn_n = 3'b111; half = 0;
    // reset state: PC low half
    expect_hex(16'h0000, "R2");
    #20ns rst_n = 1;
    // R1 R2 R3 R5 table walk
    foreach (VECS[k]) begin
      btn_n = ~VECS[k].v; half = VECS[k].h;
      expect_hex(VECS[k].e, VECS[k].v < 4 ? "R2/R5" : "R3/R5");
      @(negedge clk);
    end
    // R4 R6 R7: each control bit alone, both switch positions
    btn_n = 3'b000;
    for (int b = 0; b < 10; b++) begin
      ctrl = 10'(1 << b);
      half = 0; expect_hex(16'(1 << b), "R7");
      half = 1; expect_hex(16'(1 << b), "R6");
    end
    ctrl = 10'h3FF; half = 1; expect_hex(16'h03FF, "R4");
    // R8: every glyph
    btn_n = 3'b011; half = 0; src[4] = 32'hFEDC_BA98;
    expect_hex(16'hBA98, "R8");
    half = 1; expect_hex(16'hFEDC, "R8");
    src[4] = 32'h7654_3210;
    expect_hex(16'h7654, "R8 R9");
    half = 0; expect_hex(16'h3210, "R8");
    // R1: single button press selects code 4 (leftmost = MSB)
    btn_n = 3'b011; src[4] = 32'h0000_00A5; expect_hex(16'h00A5, "R1");
    btn_n = 3'b110; expect_hex(16'h0111, "R1");
    // R9: mid-cycle change without clock edge
    @(posedge clk); #2ns; src[1] = 32'h0000_ABCD; expect_hex(16'hABCD, "R9");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #100us; checks++; fails++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule